// File: doc/BRIEF.md
# Priority-Encoded Interrupt Controller

This block gathers up to thirteen level-sensitive interrupt requests and tells a processor with seven interrupt levels which one to take. Each request has a pending flag that tracks its input line, a mask flag, and a 5-bit control field. The upper three bits of the control field give the processor interrupt level. The lower two bits rank the source among others at that level. Among the sources that are pending and not masked, the one with the largest control value wins.

The block drives the winner's level and a vector to the processor from registers. Two sources are tied to serial ports, which supply their own vector values. Every other source gets an autovector equal to a fixed base plus its level. Software reaches the control fields, the mask word and the read-only pending word through a small synchronous register port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, cpu_level and cpu_vector are 0. Every source is masked, so the mask word at address 14 reads 0x3FFE. Every control field reads 0.
- R2: A source's pending flag copies its input line on each clock edge. The pending word at address 15 holds source n in bit n, with bit 0 always 0. A read returns the value one cycle after the address is presented.
- R3: A source whose mask bit is 1 has no effect on cpu_level or cpu_vector. The mask word at address 14 holds source n in bit n, and 1 means masked.
- R4: Among active sources (pending 1, mask 0), the one with the largest 5-bit control value wins. cpu_level equals bits 4:2 of the winner's control field. Control field n is at address n, for n from 1 to 13.
- R5: When two active sources have equal control values, the lower-numbered source wins.
- R6: When no source is active, cpu_level is 0 and cpu_vector is 0.
- R7: A winning source other than 12 or 13 produces cpu_vector = 24 + cpu_level.
- R8: If source 12 wins, cpu_vector equals ser_vec_a. If source 13 wins, cpu_vector equals ser_vec_b.
- R9: A change on an input line, or a write to a control or mask register, reaches cpu_level and cpu_vector on the second clock edge. After the first edge the outputs still hold their old values.
- R10: Writes to address 15 (pending) and to address 0 change nothing. Address 0 reads 0.
- R11: A write to a control address keeps only wdata bits 4:0. The upper bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 13 | Request lines; bit n-1 drives source n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data for addr |
| ser_vec_a | input | 8 | Vector supplied by the first serial port (source 12) |
| ser_vec_b | input | 8 | Vector supplied by the second serial port (source 13) |
| cpu_level | output | 3 | Interrupt level presented to the processor |
| cpu_vector | output | 8 | Interrupt vector presented to the processor |

## Verification
A control-register write and a change on a request line can land in the same clock. In that case arbitration must combine the new control value with the newly captured pending state. The bench drives both in one cycle. The new control value lowers the current serial-port winner, and a second higher-ranked serial source becomes pending at the same time. One cycle later the outputs must still show the old winner, and one cycle after that they must show the new winner's level and vector.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int CTRL_W = 5;
  localparam int LVL_W  = 3;
  localparam int PRI_W  = CTRL_W - LVL_W;

  typedef logic [CTRL_W-1:0] ctrl_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  function automatic lvl_t level_of(input ctrl_t c);
    return c[CTRL_W-1:PRI_W];
  endfunction
endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_SRC:1]   pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= irq_in;
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_SRC:1]               pend,
  output logic [NUM_SRC:1][CTRL_W-1:0]   ctrl,
  output logic [NUM_SRC:1]               mask,
  output logic [DATA_W-1:0]              rd_data
);
  localparam int MASK_ADDR = NUM_SRC + 1;
  localparam int PEND_ADDR = NUM_SRC + 2;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (addr == ADDR_W'(i)) rd_mux[CTRL_W-1:0] = ctrl[i];
    end
    if (addr == ADDR_W'(MASK_ADDR)) rd_mux[NUM_SRC:1] = mask;
    if (addr == ADDR_W'(PEND_ADDR)) rd_mux[NUM_SRC:1] = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      mask    <= '1;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        for (int i = 1; i <= NUM_SRC; i++) begin
          if (addr == ADDR_W'(i)) ctrl[i] <= wdata[CTRL_W-1:0];
        end
        if (addr == ADDR_W'(MASK_ADDR)) mask <= wdata[NUM_SRC:1];
      end
      rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:1]             active,
  input  logic [NUM_SRC:1][CTRL_W-1:0] ctrl,
  output logic                         any,
  output logic [IDX_W-1:0]             win_idx,
  output ctrl_t                        win_ctrl
);
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_ctrl = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (active[i] && (!any || ctrl[i] > win_ctrl)) begin
        any      = 1'b1;
        win_idx  = IDX_W'(i);
        win_ctrl = ctrl[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC      = 13,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 16,
  parameter int VEC_W        = 8,
  parameter int SER_SRC_A    = 12,
  parameter int SER_SRC_B    = 13,
  parameter int AUTOVEC_BASE = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [VEC_W-1:0]   ser_vec_a,
  input  logic [VEC_W-1:0]   ser_vec_b,
  output logic [LVL_W-1:0]   cpu_level,
  output logic [VEC_W-1:0]   cpu_vector
);
  localparam int IDX_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC:1]             pend;
  logic [NUM_SRC:1]             mask;
  logic [NUM_SRC:1][CTRL_W-1:0] ctrl;
  logic [NUM_SRC:1]             active_src;
  logic                         any_act;
  logic [IDX_W-1:0]             win_idx;
  ctrl_t                        win_ctrl;
  lvl_t                         nxt_level;
  logic [VEC_W-1:0]             nxt_vector;

  irq_pend_capture #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .pend(pend)
  );

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend(pend), .ctrl(ctrl), .mask(mask), .rd_data(rd_data)
  );

  assign active_src = pend & ~mask;

  irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .active(active_src), .ctrl(ctrl), .any(any_act),
    .win_idx(win_idx), .win_ctrl(win_ctrl)
  );

  always_comb begin
    nxt_level  = any_act ? level_of(win_ctrl) : '0;
    if (!any_act)                          nxt_vector = '0;
    else if (win_idx == IDX_W'(SER_SRC_A)) nxt_vector = ser_vec_a;
    else if (win_idx == IDX_W'(SER_SRC_B)) nxt_vector = ser_vec_b;
    else nxt_vector = VEC_W'(AUTOVEC_BASE) + VEC_W'(nxt_level);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_level  <= '0;
      cpu_vector <= '0;
    end else begin
      cpu_level  <= nxt_level;
      cpu_vector <= nxt_vector;
    end
  end
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC      = 13,
  parameter int VEC_W        = 8,
  parameter int SER_SRC_A    = 12,
  parameter int SER_SRC_B    = 13,
  parameter int AUTOVEC_BASE = 24
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_SRC-1:0]           irq_in,
  input logic [NUM_SRC:1]             pend,
  input logic [NUM_SRC:1]             active,
  input logic [NUM_SRC:1][CTRL_W-1:0] ctrl,
  input logic [VEC_W-1:0]             ser_vec_a,
  input logic [VEC_W-1:0]             ser_vec_b,
  input logic [LVL_W-1:0]             cpu_level,
  input logic [VEC_W-1:0]             cpu_vector
);
  p_pend_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pend == $past(irq_in));

  p_idle_out_r6: assert property (@(posedge clk) disable iff (rst)
    ($countones(active) == 0) |=> (cpu_level == '0 && cpu_vector == '0));

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
    p_sole_level_r4: assert property (@(posedge clk) disable iff (rst)
      (active[i] && $countones(active) == 1) |=> cpu_level == $past(ctrl[i][CTRL_W-1:PRI_W]));

    if (i == SER_SRC_A) begin : g_sa
      p_ser_vec_a_r8: assert property (@(posedge clk) disable iff (rst)
        (active[i] && $countones(active) == 1) |=> cpu_vector == $past(ser_vec_a));
    end else if (i == SER_SRC_B) begin : g_sb
      p_ser_vec_b_r8: assert property (@(posedge clk) disable iff (rst)
        (active[i] && $countones(active) == 1) |=> cpu_vector == $past(ser_vec_b));
    end else begin : g_av
      p_autovec_r7: assert property (@(posedge clk) disable iff (rst)
        (active[i] && $countones(active) == 1) |=>
          cpu_vector == VEC_W'(AUTOVEC_BASE) + VEC_W'($past(ctrl[i][CTRL_W-1:PRI_W])));
    end
  end
endmodule

bind irq_prio_ctrl irq_prio_checker #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .SER_SRC_A(SER_SRC_A),
  .SER_SRC_B(SER_SRC_B), .AUTOVEC_BASE(AUTOVEC_BASE)
) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .pend(pend), .active(active_src),
  .ctrl(ctrl), .ser_vec_a(ser_vec_a), .ser_vec_b(ser_vec_b),
  .cpu_level(cpu_level), .cpu_vector(cpu_vector)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_data;
  logic [7:0]  ser_vec_a = 8'h40;
  logic [7:0]  ser_vec_b = 8'h48;
  logic [2:0]  cpu_level;
  logic [7:0]  cpu_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [2:0] lvl; logic [7:0] vec; string tag; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .ser_vec_a(ser_vec_a), .ser_vec_b(ser_vec_b),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  // Monitor: compares outputs against queued expectations at negedge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (cpu_level !== e.lvl || cpu_vector !== e.vec) begin
          errors++;
          $display("FAIL %s: level/vector got %0d/0x%02h expected %0d/0x%02h",
                   e.tag, cpu_level, cpu_vector, e.lvl, e.vec);
        end
      end
    end
  end

  task automatic push_exp(input logic [2:0] l, input logic [7:0] v, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.lvl = l; e.vec = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic check_val(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_lines(input logic [13:1] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a;
    @(negedge clk);
    check_val(rd_data, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    checks++;
    if (cpu_level !== 3'd0 || cpu_vector !== 8'd0) begin
      errors++;
      $display("FAIL R1: got %0d/0x%02h expected 0/0x00", cpu_level, cpu_vector);
    end
    rd_chk(4'd14, 16'h3FFE, "R1 mask reset");
    rd_chk(4'd1,  16'h0000, "R1 ctrl reset");

    // R3: pending but masked source has no effect
    wr(4'd3, 16'h0016);
    set_lines(13'h0008 >> 1 << 1 >> 1);
    push_exp(3'd0, 8'd0, "R3 masked source");
    rd_chk(4'd15, 16'h0008, "R2 pending word");

    // R4/R7: unmask source 3 -> level 5, vector 29
    wr(4'd14, 16'h3FF6);
    push_exp(3'd5, 8'd29, "R4 R7 single source");

    // R4: higher control value on source 5 wins
    wr(4'd5, 16'h001C);
    set_lines(13'h0014);
    wr(4'd14, 16'h3FD6);
    push_exp(3'd7, 8'd31, "R4 higher ctrl wins");

    // R3: masking source 5 again
    wr(4'd14, 16'h3FF6);
    push_exp(3'd5, 8'd29, "R3 remask drops winner");

    // R5: tie between source 9 and 12
    wr(4'd9,  16'h0015);
    wr(4'd12, 16'h0015);
    set_lines(13'h0900);
    wr(4'd14, 16'h2DFE);
    push_exp(3'd5, 8'd29, "R5 tie lower index");

    // R8: source 12 alone
    set_lines(13'h0800);
    push_exp(3'd5, 8'h40, "R8 serial A vector");

    // R8: source 13 higher
    wr(4'd13, 16'h0019);
    set_lines(13'h1800);
    wr(4'd14, 16'h0DFE);
    push_exp(3'd6, 8'h48, "R8 serial B vector");

    // R6: no active source
    set_lines(13'h0000);
    push_exp(3'd0, 8'd0, "R6 idle output");
    rd_chk(4'd15, 16'h0000, "R2 pending cleared");

    // R10: writes to pending and address 0 ignored
    set_lines(13'h0800);
    wr(4'd15, 16'hFFFF);
    wr(4'd0,  16'h1234);
    push_exp(3'd5, 8'h40, "R10 ignored writes output");
    rd_chk(4'd15, 16'h1000, "R10 pending unchanged");
    rd_chk(4'd0,  16'h0000, "R10 address 0 reads zero");

    // R11: control field keeps 5 bits
    wr(4'd1, 16'h00FF);
    rd_chk(4'd1, 16'h001F, "R11 ctrl width");

    // R9: same-cycle control write and line change
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd12; wdata = 16'h000D; irq_in = 13'h1800;
    @(negedge clk);
    wr_en = 1'b0;
    checks++;
    if (cpu_level !== 3'd5 || cpu_vector !== 8'h40) begin
      errors++;
      $display("FAIL R9 first edge: got %0d/0x%02h expected 5/0x40", cpu_level, cpu_vector);
    end
    push_exp(3'd6, 8'h48, "R9 second edge");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule